// File: doc/BRIEF.md
# Prescaled PWM Channel with Synchronised Settings

This block produces one pulse-width-modulated output from a byte-wide register port. A reference tick is picked from three single-cycle enable inputs (slow, medium, fast) that all belong to the system clock domain. The block divides that tick first by a small non-power-of-two factor and then by a power of two. The result advances a 9-bit period counter, and the output stays high while the counter is below the duty value.

Clock selection, divider and duty writes land in shadow registers. They reach the running waveform only after a sync command. With the smooth-update mode off, a sync applies on the next clock. With it on, a sync waits for the end of the current period, so a period is never cut short or stretched. A status bit shows that a deferred sync is still waiting. Output gating, the source select and the pad-drive enable act at once and are not shadowed.

Top module: `scaled_pwm`

## Requirements
- R1: Clock select code 0 stops the channel. Codes 1, 2 and 3 take `tick_i[0]` (slow), `tick_i[1]` (medium) and `tick_i[2]` (fast) as the reference tick. The code is written to address 0x1, bits [1:0].
- R2: Divider register address 0x2, bits [6:5], give a pre-divide of 1, 3, 5 or 6 reference ticks for codes 0 to 3.
- R3: Divider register bits [2:0] give an exponent e from 0 to 7, which adds a further divide by 2^e. One period therefore lasts 512 × prediv × 2^e reference ticks.
- R4: The output is high while the 9-bit counter is below the active duty. Duty 0 keeps it low. Duty 512 or more keeps it high for the whole period.
- R5: The 16-bit duty is written as a low byte at address 0x3 and a high byte at address 0x4.
- R6: Control register 0x5 bit 7 is run enable. When it is clear, or when the active clock select is 0, the counter holds at zero and `pwm_o` is low.
- R7: Control register bit 2 is source select. When it is clear, `pwm_o` is low. Bit 5 drives `oe_o` directly.
- R8: Writes to 0x1 to 0x4 have no effect on `pwm_o` until a write of 1 to bit 0 of address 0x6.
- R9: With smooth mode off (address 0x0 bit 5 = 0), a sync makes the shadow settings active from the next clock. Pending reads 0.
- R10: With smooth mode on while the counter runs, a sync sets pending (address 0x6 bit 7). The transfer happens on the 511→0 counter wrap, within one period, and pending then clears. If the counter is halted, the sync applies at once.
- R11: Reads return the shadow values at their bit positions. Unused bits read 0 and unmapped addresses read 0.
- R12: After reset all registers are zero and `pwm_o` and `oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Reference enable ticks: [0] slow, [1] medium, [2] fast |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM waveform |
| oe_o | output | 1 | Pad drive enable |

## Verification
Assertions check four things on every cycle:
- the active settings change only after a sync command or a pending transfer;
- a deferred sync stays pending until a wrap;
- a prescaled tick never occurs without the selected reference tick;
- a halted counter never lets the output go high.

Only the bench scenarios can show the rest:
- the high-time count per full period for each clock source, divider code and exponent, including duty values of 0 and above 512;
- that shadow writes do not disturb the waveform;
- that a deferred sync resolves within one period and with the new duty.

// File: rtl/scaled_pwm_pkg.sv
package scaled_pwm_pkg;
  localparam int RES_W  = 9;
  localparam int EXP_W  = 3;
  localparam int DUTY_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] A_CSEL = 4'h1;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DLO  = 4'h3;
  localparam logic [ADDR_W-1:0] A_DHI  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h5;
  localparam logic [ADDR_W-1:0] A_SYNC = 4'h6;

  typedef struct packed {
    logic [1:0]        csel;
    logic [1:0]        pdiv;
    logic [EXP_W-1:0]  expo;
    logic [DUTY_W-1:0] duty;
  } pwm_cfg_t;

  function automatic logic [2:0] pdiv_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import scaled_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic              run_i,
  input  logic              wrap_i,
  output pwm_cfg_t          act_o,
  output logic              run_en_o,
  output logic              src_o,
  output logic              buf_o
);
  pwm_cfg_t shd_q, act_q;
  logic smooth_q, pend_q;
  logic sync_wr, apply;

  assign sync_wr = we_i && (addr_i == A_SYNC) && wdata_i[0];
  // transfer now, or defer to the period wrap in smooth mode
  assign apply = (sync_wr && (!smooth_q || !run_i || wrap_i)) ||
                 (pend_q && (wrap_i || !run_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q    <= '0;
      act_q    <= '0;
      smooth_q <= 1'b0;
      pend_q   <= 1'b0;
      run_en_o <= 1'b0;
      src_o    <= 1'b0;
      buf_o    <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_MODE: smooth_q      <= wdata_i[5];
          A_CSEL: shd_q.csel    <= wdata_i[1:0];
          A_DIV: begin
            shd_q.pdiv <= wdata_i[6:5];
            shd_q.expo <= wdata_i[EXP_W-1:0];
          end
          A_DLO:  shd_q.duty[7:0]  <= wdata_i;
          A_DHI:  shd_q.duty[15:8] <= wdata_i;
          A_CTRL: begin
            run_en_o <= wdata_i[7];
            buf_o    <= wdata_i[5];
            src_o    <= wdata_i[2];
          end
          default: ;
        endcase
      end
      if (apply) begin
        act_q  <= shd_q;
        pend_q <= 1'b0;
      end else if (sync_wr) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = {2'b0, smooth_q, 5'b0};
      A_CSEL:  rdata_o = {6'b0, shd_q.csel};
      A_DIV:   rdata_o = {1'b0, shd_q.pdiv, 2'b0, shd_q.expo};
      A_DLO:   rdata_o = shd_q.duty[7:0];
      A_DHI:   rdata_o = shd_q.duty[15:8];
      A_CTRL:  rdata_o = {run_en_o, 1'b0, buf_o, 2'b0, src_o, 2'b0};
      A_SYNC:  rdata_o = {pend_q, 7'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  assign act_o = act_q;

  // R8: active settings move only after a sync command or a pending transfer
  assert_act_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_wr && !pend_q) |=> $stable(act_q));
  // R10: a deferred sync waits while the counter runs without wrapping
  assert_pend_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && run_i && !wrap_i && !sync_wr) |=> pend_q);
  // R9: pending is only ever raised in smooth mode
  assert_pend_smooth_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(smooth_q));
endmodule

// File: rtl/spwm_prescale.sv
module spwm_prescale
  import scaled_pwm_pkg::*;
#(
  parameter int EW = EXP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [2:0]    tick_i,
  input  logic [1:0]    csel_i,
  input  logic [1:0]    pdiv_i,
  input  logic [EW-1:0] expo_i,
  output logic          stick_o
);
  localparam int XW = (2 ** EW) - 1;

  logic          ref_tick, pre_hit, exp_hit;
  logic [2:0]    pre_q, ratio;
  logic [XW-1:0] exp_q, mask;

  always_comb begin
    case (csel_i)
      2'd1:    ref_tick = tick_i[0];
      2'd2:    ref_tick = tick_i[1];
      2'd3:    ref_tick = tick_i[2];
      default: ref_tick = 1'b0;
    endcase
  end

  assign ratio   = pdiv_ratio(pdiv_i);
  // >= keeps the divider live if the ratio shrinks mid-count
  assign pre_hit = ref_tick && (pre_q >= ratio - 3'd1);
  assign mask    = XW'((XW+1)'(1) << expo_i) - XW'(1);
  assign exp_hit = (exp_q & mask) == mask;
  assign stick_o = run_i && pre_hit && exp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      exp_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      exp_q <= '0;
    end else if (ref_tick) begin
      pre_q <= pre_hit ? 3'd0 : pre_q + 3'd1;
      if (pre_hit) exp_q <= exp_q + XW'(1);
    end
  end

  // R1: a prescaled tick needs the selected reference tick
  assert_tick_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stick_o |-> (csel_i != 2'd0) && tick_i[csel_i - 2'd1]);
endmodule

// File: rtl/spwm_core.sv
module spwm_core
  import scaled_pwm_pkg::*;
#(
  parameter int CW = RES_W,
  parameter int DW = DUTY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          src_i,
  input  logic          stick_i,
  input  logic [DW-1:0] duty_i,
  output logic          wrap_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (stick_i) cnt_q <= cnt_q + CW'(1);
  end

  assign wrap_o = run_i && stick_i && (&cnt_q);
  assign pwm_o  = run_i && src_i && ({{(DW-CW){1'b0}}, cnt_q} < duty_i);

  // R6: a halted channel keeps its output low
  assert_halt_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o);
  // R4: the counter only moves on a prescaled tick
  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !stick_i) |=> $stable(cnt_q));
  // R4: a wrap starts the next period at zero
  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/scaled_pwm.sv
module scaled_pwm
  import scaled_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] tick_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic [7:0] rdata_o,
  output logic       pwm_o,
  output logic       oe_o
);
  pwm_cfg_t act;
  logic run_en, src, buf_en, run, wrap, stick;

  assign run  = run_en && (act.csel != 2'd0);
  assign oe_o = buf_en;

  spwm_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .run_i(run), .wrap_i(wrap), .act_o(act),
    .run_en_o(run_en), .src_o(src), .buf_o(buf_en)
  );

  spwm_prescale #(.EW(EXP_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .tick_i,
    .csel_i(act.csel), .pdiv_i(act.pdiv), .expo_i(act.expo),
    .stick_o(stick)
  );

  spwm_core #(.CW(RES_W), .DW(DUTY_W)) u_core (
    .clk_i, .rst_ni, .run_i(run), .src_i(src), .stick_i(stick),
    .duty_i(act.duty), .wrap_o(wrap), .pwm_o
  );
endmodule

// File: tb/scaled_pwm_bench.sv
module scaled_pwm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {csel[1:0], pdiv[1:0], expo[2:0], duty[15:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd3, 2'd0, 3'd0, 16'd100},
    {2'd3, 2'd1, 3'd0, 16'd256},
    {2'd3, 2'd2, 3'd1, 16'd50},
    {2'd3, 2'd3, 3'd0, 16'd511},
    {2'd2, 2'd0, 3'd2, 16'd300},
    {2'd1, 2'd1, 3'd0, 16'd10},
    {2'd3, 2'd0, 3'd0, 16'd600},
    {2'd3, 2'd0, 3'd0, 16'd0},
    {2'd3, 2'd0, 3'd7, 16'd1}
  };

  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] tick = '0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic pwm, oe;
  int n_chk = 0, n_fail = 0, phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // fast every cycle, medium every 2nd, slow every 4th
  always @(negedge clk) begin
    tick  <= {1'b1, (phase % 2) == 0, (phase % 4) == 0};
    phase <= phase + 1;
  end

  scaled_pwm u_scaled_pwm (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .pwm_o(pwm), .oe_o(oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic count_high(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwm) n++;
    end
  endtask

  task automatic setup(input logic [1:0] cs, input logic [1:0] pd,
                       input logic [2:0] ex, input logic [15:0] du);
    wr(4'h5, 8'h00);
    wr(4'h1, {6'b0, cs});
    wr(4'h2, {1'b0, pd, 2'b0, ex});
    wr(4'h3, du[7:0]);
    wr(4'h4, du[15:8]);
    wr(4'h6, 8'h01);
    wr(4'h5, 8'ha4);
    repeat (3) @(negedge clk);
  endtask

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 3;
      2'd2: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int rate(input logic [1:0] c);
    return (c == 2'd3) ? 1 : (c == 2'd2) ? 2 : 4;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, n, w, scale, hi;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 pwm", pwm, 0);
    chk("R12 oe", oe, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a[3:0], v);
      chk("R12 reg zero", v, 0);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4: vector walk, high count over one full period
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] cs, pd; logic [2:0] ex; logic [15:0] du;
      {cs, pd, ex, du} = VEC[k];
      setup(cs, pd, ex, du);
      scale = ratio(pd) * (1 << ex) * rate(cs);
      hi = (du > 512) ? 512 : int'(du);
      count_high(512 * scale, n);
      chk("R1 R2 R3 R4 high count", n, hi * scale);
    end

    // R5 R11: readback of shadow values and layout
    setup(2'd3, 2'd2, 3'd5, 16'h1234);
    rd(4'h3, v); chk("R5 duty lo", v, 8'h34);
    rd(4'h4, v); chk("R5 duty hi", v, 8'h12);
    rd(4'h2, v); chk("R11 div read", v, 8'h45);
    rd(4'h1, v); chk("R11 csel read", v, 3);
    rd(4'h5, v); chk("R11 ctrl read", v, 8'ha4);
    rd(4'h9, v); chk("R11 unmapped", v, 0);
    chk("R7 oe follows bit5", oe, 1);

    // R8: shadow writes alone leave the waveform alone
    setup(2'd3, 2'd0, 3'd0, 16'd100);
    wr(4'h3, 8'd200);
    wr(4'h2, 8'h01);
    count_high(512, n);
    chk("R8 no sync no effect", n, 100);
    // R9: immediate sync
    wr(4'h2, 8'h00);
    wr(4'h6, 8'h01);
    rd(4'h6, v); chk("R9 pending clear", v, 0);
    count_high(512, n);
    chk("R9 new duty applied", n, 200);

    // R7: source select clear forces low, buffer bit off
    wr(4'h5, 8'h80);
    count_high(512, n);
    chk("R7 src off low", n, 0);
    chk("R7 oe off", oe, 0);

    // R6: run enable clear and clock select 0
    wr(4'h5, 8'h24);
    count_high(512, n);
    chk("R6 disabled low", n, 0);
    setup(2'd0, 2'd0, 3'd0, 16'd300);
    count_high(512, n);
    chk("R6 csel zero low", n, 0);

    // R10: deferred sync in smooth mode
    setup(2'd3, 2'd0, 3'd0, 16'd100);
    wr(4'h0, 8'h20);
    wr(4'h3, 8'h90);
    wr(4'h4, 8'h01);
    wr(4'h6, 8'h01);
    rd(4'h6, v); chk("R10 pending set", v, 8'h80);
    w = 0;
    while (rdata[7] && w < 700) begin
      @(negedge clk); w++;
    end
    chk("R10 resolves within period", int'(w <= 512), 1);
    chk("R10 new period high", pwm, 1);
    count_high(512, n);
    chk("R10 deferred duty", n, 400);
    rd(4'h0, v); chk("R11 mode read", v, 8'h20);

    // R10: halted counter makes a smooth sync immediate
    wr(4'h5, 8'h00);
    wr(4'h3, 8'd50); wr(4'h4, 8'd0);
    wr(4'h6, 8'h01);
    rd(4'h6, v); chk("R10 halted immediate", v, 0);
    wr(4'h5, 8'ha4);
    repeat (2) @(negedge clk);
    count_high(512, n);
    chk("R10 halted duty", n, 50);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule